// File: doc/BRIEF.md
# Receive DC Offset Compensator

This block sits directly behind a receiver's I/Q analog-to-digital converters. It removes the DC offset from the signed baseband samples. It also drives the control line that puts the analog baseband high-pass filter into its fast-settling mode. That line is held high while gains may still change, which lets the large kick that a gain change causes die out quickly. It is released only after the gain controller reports that it has settled. The line is named `hp_fast` here.

Once the line is released, the block averages a window of 2^N samples on each channel on its own. From then on it subtracts that estimate. The estimate then serves as the starting point of a slow first-order high-pass tracker. The tracker follows the residual drift until the packet ends or a new gain change is requested.

Outside a packet, samples pass through unchanged. Corrected samples are clamped to the input width.

Top module: `rx_dc_comp`

## Requirements
- R1: When `gain_req` is high in any state, `hp_fast` is high from the next clock on. An averaging or tracking pass in progress is abandoned, and its partial sum is discarded.
- R2: While idle, `hp_fast` is high and `ready` is low. Each sample with `in_valid` high appears unchanged on `out_i`/`out_q`, with `out_valid` high, one clock later.
- R3: `hp_fast` falls only on the clock after a cycle in which the block was idle, `agc_done` was high and `gain_req` was low.
- R4: In the averaging state, `out_valid` stays low. The first 2^N valid samples are summed per channel. The mean is that sum shifted arithmetically right by N, which is floor(sum / 2^N). The block enters tracking on the clock after the 2^N-th valid sample.
- R5: In tracking, each valid sample x gives, one clock later, y = x - floor(A / 2^K) on the same channel. A is a per-channel accumulator with K fractional bits. A starts at mean·2^K and is updated after each sample as A += floor((x·2^K - A) / 2^K).
- R6: The I and Q channels keep fully separate sums, means and accumulators, so opposite offsets on the two channels are each removed.
- R7: A corrected sample is saturated to the range [-2^(W-1), 2^(W-1)-1] and never wraps.
- R8: `ready` is high exactly while the block is in the tracking state.
- R9: A high `pkt_end` during averaging or tracking returns the block to idle on the next clock, and the sample of that cycle produces no output. The next packet averages again from zero.
- R10: After reset, the block is idle: `hp_fast` is 1, and `ready` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | Signed in-phase sample |
| in_q | input | W | Signed quadrature sample |
| gain_req | input | 1 | Gain change requested |
| agc_done | input | 1 | Gain controller has settled |
| pkt_end | input | 1 | Packet has ended |
| hp_fast | output | 1 | Analog high-pass fast-settle control |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | W | Corrected in-phase sample |
| out_q | output | W | Corrected quadrature sample |
| ready | output | 1 | Tracking correction active |

## Verification
The assertions assume that `agc_done` arrives as a strobe while the block is idle. They also assume that `gain_req` and `pkt_end` may come in any state, and that the samples lie within the signed W-bit range. The stimulus uses $urandom with a fixed seed to choose the valid gaps, the noise, the offsets, the packet lengths and the kind of packet end. Every sample is clamped to W bits. Directed packets cover these cases: an abort during averaging, an abort during tracking, and step changes large enough to drive both channels into saturation in opposite directions.

// File: rtl/rx_dc_pkg.sv
package rx_dc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_AVG   = 2'd1,
        ST_TRACK = 2'd2
    } dc_state_e;

    typedef struct packed {
        logic clear;   // start a new estimate
        logic accum;   // add the sample to the running sum
        logic load;    // last window sample: form the mean
        logic track;   // apply the tracker to the sample
        logic pass;    // forward the sample unchanged
    } chan_ctl_t;

    function automatic logic is_abort(input logic gain_req, input logic pkt_end);
        return gain_req | pkt_end;
    endfunction

endpackage

// File: rtl/dc_ctrl.sv
module dc_ctrl
    import rx_dc_pkg::*;
#(
    parameter int N = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      gain_req,
    input  logic      agc_done,
    input  logic      pkt_end,
    output chan_ctl_t ctl,
    output logic      hp_fast,
    output logic      ready
);
    dc_state_e      state;
    logic [N-1:0]   cnt;
    logic           abort;

    always_comb begin
        abort     = is_abort(gain_req, pkt_end);
        ctl.clear = (state == ST_IDLE) && agc_done && !gain_req;
        ctl.pass  = (state == ST_IDLE) && in_valid;
        ctl.accum = (state == ST_AVG) && !abort && in_valid;
        ctl.load  = ctl.accum && (cnt == '1);
        ctl.track = (state == ST_TRACK) && !abort && in_valid;
        hp_fast   = (state == ST_IDLE);
        ready     = (state == ST_TRACK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ctl.clear) begin
                        state <= ST_AVG;
                        cnt   <= '0;
                    end
                end
                ST_AVG: begin
                    if (abort) state <= ST_IDLE;
                    else if (ctl.load) state <= ST_TRACK;
                    else if (ctl.accum) cnt <= cnt + 1'b1;
                end
                ST_TRACK: begin
                    if (abort) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a gain request forces the fast-settle line high on the next clock
    p_hp_on_gain_r1: assert property (@(posedge clk) disable iff (rst)
        gain_req |=> hp_fast);

    // R3: the line is released only right after the settle strobe
    p_hp_fall_after_done_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(hp_fast) |-> $past(agc_done) && !$past(gain_req));

endmodule

// File: rtl/dc_chan.sv
module dc_chan #(
    parameter int W = 12,
    parameter int N = 6,
    parameter int K = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  rx_dc_pkg::chan_ctl_t ctl,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    localparam int SW = W + N;       // running sum width
    localparam int AW = W + K + 1;   // accumulator with K fraction bits

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] total;
    logic signed [W:0]    mean;
    logic signed [AW-1:0] acc;
    logic signed [AW:0]   err;
    logic signed [AW-1:0] step;
    logic signed [W:0]    acc_int;
    logic signed [W+1:0]  diff;
    logic signed [W-1:0]  sat;

    always_comb begin
        total   = sum + SW'(x);
        mean    = (W+1)'(total >>> N);
        err     = ((AW+1)'(x) <<< K) - (AW+1)'(acc);
        step    = AW'(err >>> K);
        acc_int = (W+1)'(acc >>> K);
        diff    = (W+2)'(x) - (W+2)'(acc_int);
        if (diff[W+1:W-1] == 3'b000 || diff[W+1:W-1] == 3'b111)
            sat = diff[W-1:0];
        else if (diff[W+1])
            sat = {1'b1, {(W-1){1'b0}}};
        else
            sat = {1'b0, {(W-1){1'b1}}};
        y = ctl.pass ? x : sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
            acc <= '0;
        end else begin
            if (ctl.clear)
                sum <= '0;
            else if (ctl.accum)
                sum <= total;
            if (ctl.load)
                acc <= AW'(mean) <<< K;
            else if (ctl.track)
                acc <= acc + step;
        end
    end

endmodule

// File: rtl/rx_dc_comp.sv
module rx_dc_comp
    import rx_dc_pkg::*;
#(
    parameter int W = 12,
    parameter int N = 6,
    parameter int K = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    input  logic                gain_req,
    input  logic                agc_done,
    input  logic                pkt_end,
    output logic                hp_fast,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q,
    output logic                ready
);
    localparam int NCH = 2;

    chan_ctl_t           ctl;
    logic signed [W-1:0] xs [NCH];
    logic signed [W-1:0] ys [NCH];

    assign xs[0] = in_i;
    assign xs[1] = in_q;

    dc_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .gain_req (gain_req),
        .agc_done (agc_done),
        .pkt_end  (pkt_end),
        .ctl      (ctl),
        .hp_fast  (hp_fast),
        .ready    (ready)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dc_chan #(.W(W), .N(N), .K(K)) u_chan (
            .clk (clk),
            .rst (rst),
            .ctl (ctl),
            .x   (xs[c]),
            .y   (ys[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= ctl.pass | ctl.track;
            if (ctl.pass | ctl.track) begin
                out_i <= ys[0];
                out_q <= ys[1];
            end
        end
    end

    // R4: nothing is emitted for a sample taken while averaging
    p_no_out_in_avg_r4: assert property (@(posedge clk) disable iff (rst)
        (!hp_fast && !ready) |=> !out_valid);

    // R4: tracking is entered only from averaging, on a valid sample
    p_track_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(!hp_fast && !ready && in_valid));

    // R9: a packet end during a packet returns to idle on the next clock
    p_pkt_end_idle_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> hp_fast && !ready);

endmodule

// File: tb/rx_dc_comp_tb.sv
module rx_dc_comp_tb;
    localparam int W = 12;
    localparam int N = 6;
    localparam int K = 10;
    localparam longint MAXV = (1 << (W-1)) - 1;
    localparam longint MINV = -(1 << (W-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_i = '0;
    logic signed [W-1:0] in_q = '0;
    logic gain_req = 1'b0, agc_done = 1'b0, pkt_end = 1'b0;
    logic hp_fast, out_valid, ready;
    logic signed [W-1:0] out_i, out_q;

    always #4 clk = ~clk;   // 125 MHz

    rx_dc_comp #(.W(W), .N(N), .K(K)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .gain_req(gain_req), .agc_done(agc_done), .pkt_end(pkt_end),
        .hp_fast(hp_fast), .out_valid(out_valid), .out_i(out_i),
        .out_q(out_q), .ready(ready)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    int     mst = 0;           // 0 idle, 1 average, 2 track
    int     mcnt = 0;
    longint msum [2];
    longint macc [2];
    bit     e_v = 0, e_hp = 1, e_rdy = 0;
    longint e_i = 0, e_q = 0;
    string  tag_hp = "R10", tag_i = "R2", tag_q = "R2";

    function automatic longint clamp(longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic longint track_one(int c, longint x);
        longint y;
        y = clamp(x - (macc[c] >>> K));
        macc[c] = macc[c] + (((x <<< K) - macc[c]) >>> K);
        return y;
    endfunction

    task automatic step(bit v, longint xi, longint xq, bit g, bit d, bit p);
        @(negedge clk);
        chk(tag_hp, "hp_fast", hp_fast, e_hp);
        chk("R8", "ready", ready, e_rdy);
        chk("R4", "out_valid", out_valid, e_v);
        if (e_v) begin
            chk(tag_i, "out_i", out_i, e_i);
            chk(tag_q, "out_q", out_q, e_q);
        end
        case (mst)
            0: begin
                e_v = v; e_i = xi; e_q = xq; tag_i = "R2"; tag_q = "R2";
                if (d && !g) begin
                    mst = 1; mcnt = 0; msum[0] = 0; msum[1] = 0; tag_hp = "R3";
                end else tag_hp = g ? "R1" : "R2";
            end
            1: begin
                e_v = 0;
                if (g || p) begin mst = 0; tag_hp = g ? "R1" : "R9"; end
                else if (v) begin
                    msum[0] += xi; msum[1] += xq;
                    if (mcnt == (1 << N) - 1) begin
                        macc[0] = (msum[0] >>> N) <<< K;
                        macc[1] = (msum[1] >>> N) <<< K;
                        mst = 2;
                    end else mcnt++;
                end
            end
            default: begin
                if (g || p) begin e_v = 0; mst = 0; tag_hp = g ? "R1" : "R9"; end
                else begin
                    e_v = v;
                    if (v) begin
                        e_i = track_one(0, xi); e_q = track_one(1, xq);
                        tag_i = (e_i == MAXV || e_i == MINV) ? "R7" : "R5";
                        tag_q = (e_q == MAXV || e_q == MINV) ? "R7" : "R6";
                    end
                end
            end
        endcase
        e_hp = (mst == 0); e_rdy = (mst == 2);
        in_valid = v; in_i = W'(xi); in_q = W'(xq);
        gain_req = g; agc_done = d; pkt_end = p;
    endtask

    function automatic longint noise();
        return longint'($urandom_range(0, 40)) - 20;
    endfunction

    // one packet: idle gap, settle strobe, len cycles, then an end event
    task automatic packet(int oi, int oq, int ji, int jq, int jat, int len, bit by_gain);
        longint xi, xq;
        for (int t = 0; t < 4; t++)
            step($urandom_range(0, 1), clamp(oi + noise()), clamp(oq + noise()), 0, 0, 0);
        step(1, clamp(oi + noise()), clamp(oq + noise()), 0, 1, 0);
        for (int t = 0; t < len; t++) begin
            xi = clamp(oi + (t >= jat ? ji : 0) + t / 64 + noise());
            xq = clamp(oq + (t >= jat ? jq : 0) - t / 80 + noise());
            step($urandom_range(0, 9) < 8, xi, xq, 0, 0, 0);
        end
        step(1, oi, oq, by_gain, 0, !by_gain);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        msum[0] = 0; msum[1] = 0; macc[0] = 0; macc[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state (checked by the first step)
        step(0, 0, 0, 0, 0, 0);
        // R2: idle pass-through with random samples
        for (int t = 0; t < 20; t++)
            step($urandom_range(0, 1), longint'($urandom_range(0, 4095)) - 2048,
                 longint'($urandom_range(0, 4095)) - 2048, 0, 0, 0);
        // R6: opposite offsets on I and Q, full packet
        packet(472, -350, 0, 0, 9999, 400, 0);
        // R1: gain request during averaging, then a clean packet
        packet(300, 200, 0, 0, 9999, 40, 1);
        packet(-100, 600, 0, 0, 9999, 200, 0);
        // R1: gain request during tracking
        packet(50, -50, 0, 0, 9999, 150, 1);
        // R3: settle strobe together with gain request stays idle
        step(1, 10, 20, 1, 1, 0);
        step(1, 11, 21, 0, 0, 0);
        // R7: saturation in both directions
        packet(-1900, 1900, 3900, -3900, 100, 160, 0);
        // random packets
        for (int n = 0; n < 40; n++)
            packet(int'($urandom_range(0, 2000)) - 1000, int'($urandom_range(0, 2000)) - 1000,
                   int'($urandom_range(0, 400)) - 200, int'($urandom_range(0, 400)) - 200,
                   int'($urandom_range(0, 300)), int'($urandom_range(10, 300)),
                   $urandom_range(0, 1));
        step(0, 0, 0, 0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule